// File: doc/BRIEF.md
# CPU Interrupt Pending and Mask Unit

This block holds the interrupt-related part of a processor's control registers. Eight interrupt lines feed it. Lines 0 and 1 are software lines, whose pending state software sets and clears through register writes. Lines 2 to 7 are level-sensitive hardware lines. Their pending state is the live input level, so a line clears only when its device releases it. When a counter is present (parameter `HAS_TIMER` = 1, the default), line 7 is driven by the timer compare input instead of the top hardware pin.

A status register holds a per-line enable field in bits 15:8 and a global enable in bit 0. A cause register shows the per-line pending field in bits 15:8. The unit ANDs the pending field with the enable field. It raises a registered interrupt request and reports the index of the highest-numbered line that is both pending and enabled. Software reaches both registers through a one-bit-address register port with a combinational read-back.

Top module: `cpu_irq_unit`

## Requirements
- R1: After reset, status reads 0 and the software pending bits are 0. `irq_o` and `irq_id_o` are 0.
- R2: A write with `addr_i`=0 stores all 16 bits of `wdata_i` into status, and status reads back exactly what was written. Bits 15:8 enable lines 7..0 (bit 8+n enables line n) and bit 0 is the global enable. Status changes on no other cycle.
- R3: A write with `addr_i`=1 loads software pending bits 1:0 from `wdata_i[9:8]`, so the written value wins. All other written bits are ignored. Cause reads 0 in bits 7:0, and bits 15:10 show only the hardware levels.
- R4: Cause bit 8+n for n = 2..6 follows the live level of `hw_irq_i[n-2]`. A cause write cannot clear it.
- R5: With `HAS_TIMER`=1, cause bit 15 and line 7 follow `timer_irq_i`, and `hw_irq_i[5]` has no effect.
- R6: On each clock edge, `irq_o` is loaded with (global enable AND (pending AND enable field) is non-zero), using the values before that edge. The output therefore lags by one clock.
- R7: `irq_id_o` is loaded on the same edge with the highest index set in (pending AND enable field), or 0 when that set is empty. The global enable does not gate it.
- R8: A line whose enable bit is 0, or any line while the global enable is 0, never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 status, 1 cause |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read-back of the selected register |
| hw_irq_i | input | 6 | Hardware levels for lines 2..7 |
| timer_irq_i | input | 1 | Timer compare level, drives line 7 when a counter is present |
| irq_o | output | 1 | Registered interrupt request |
| irq_id_o | output | 3 | Registered index of the highest enabled pending line |

## Verification
The bench fills every cause bit with a write of all ones and then expects only bits 9:8 to stick. A unit that stored the whole field would show phantom hardware pending bits, and then a phantom request. It holds a hardware line high while software writes zero to cause, which catches a design that lets writes clear level bits. It also raises several lines together, so that an encoder that favours the lowest index reports the wrong line. It then clears the global enable while lines stay pending, and clears single enable bits, to catch a request that leaks past either gate. Finally it asserts the top hardware pin with the timer low, to catch line 7 being taken from the wrong source.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_CAUSE  = 1'b1
  } reg_sel_e;

  localparam int unsigned GIE_BIT = 0;
endpackage

// File: rtl/irq_csr.sv
module irq_csr
  import irq_unit_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned N_LINES   = 8,
  parameter int unsigned N_SW      = 2,
  parameter int unsigned FIELD_LSB = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  reg_sel_e           sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] mask_o,
  output logic               gie_o,
  output logic [N_SW-1:0]    sw_pend_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] status_q;
  logic [N_SW-1:0]   sw_q;
  logic [DATA_W-1:0] cause_img;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      sw_q     <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_STATUS) status_q <= wdata_i;
      else                     sw_q     <= wdata_i[FIELD_LSB +: N_SW];
    end
  end

  always_comb begin
    cause_img = '0;
    cause_img[FIELD_LSB +: N_LINES] = lines_i;
  end

  assign rdata_o   = (sel_i == SEL_STATUS) ? status_q : cause_img;
  assign mask_o    = status_q[FIELD_LSB +: N_LINES];
  assign gie_o     = status_q[GIE_BIT];
  assign sw_pend_o = sw_q;
endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux #(
  parameter int unsigned N_LINES   = 8,
  parameter int unsigned N_SW      = 2,
  parameter bit          HAS_TIMER = 1'b1
) (
  input  logic [N_SW-1:0]         sw_i,
  input  logic [N_LINES-N_SW-1:0] hw_i,
  input  logic                    timer_i,
  output logic [N_LINES-1:0]      lines_o
);
  localparam int unsigned N_HW = N_LINES - N_SW;

  logic top_line;

  // top line comes from the counter compare when one is fitted
  assign top_line = HAS_TIMER ? timer_i : hw_i[N_HW-1];
  assign lines_o  = {top_line, hw_i[N_HW-2:0], sw_i};
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned ID_W   = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] req_i,
  output logic               any_o,
  output logic [ID_W-1:0]    id_o
);
  logic [N_LINES-1:0] win;

  // a line wins when no higher-numbered line requests
  for (genvar i = 0; i < N_LINES; i++) begin : g_win
    if (i == N_LINES - 1) begin : g_top
      assign win[i] = req_i[i];
    end else begin : g_low
      assign win[i] = req_i[i] & ~(|req_i[N_LINES-1:i+1]);
    end
  end

  always_comb begin
    id_o = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (win[i]) id_o = ID_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/cpu_irq_unit.sv
module cpu_irq_unit
  import irq_unit_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned N_LINES   = 8,
  parameter int unsigned N_SW      = 2,
  parameter int unsigned FIELD_LSB = 8,
  parameter bit          HAS_TIMER = 1'b1,
  localparam int unsigned ID_W     = $clog2(N_LINES),
  localparam int unsigned N_HW     = N_LINES - N_SW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_HW-1:0]   hw_irq_i,
  input  logic              timer_irq_i,
  output logic              irq_o,
  output logic [ID_W-1:0]   irq_id_o
);
  logic [N_LINES-1:0] lines_w;
  logic [N_LINES-1:0] mask_w;
  logic [N_LINES-1:0] eff_w;
  logic [N_SW-1:0]    sw_w;
  logic               gie_w;
  logic               any_w;
  logic [ID_W-1:0]    id_w;
  logic               irq_q;
  logic [ID_W-1:0]    id_q;
  reg_sel_e           sel_w;

  assign sel_w = reg_sel_e'(addr_i);

  irq_csr #(
    .DATA_W   (DATA_W),
    .N_LINES  (N_LINES),
    .N_SW     (N_SW),
    .FIELD_LSB(FIELD_LSB)
  ) u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .sel_i    (sel_w),
    .wdata_i  (wdata_i),
    .lines_i  (lines_w),
    .mask_o   (mask_w),
    .gie_o    (gie_w),
    .sw_pend_o(sw_w),
    .rdata_o  (rdata_o)
  );

  irq_line_mux #(
    .N_LINES  (N_LINES),
    .N_SW     (N_SW),
    .HAS_TIMER(HAS_TIMER)
  ) u_mux (
    .sw_i   (sw_w),
    .hw_i   (hw_irq_i),
    .timer_i(timer_irq_i),
    .lines_o(lines_w)
  );

  assign eff_w = lines_w & mask_w;

  irq_prio_enc #(
    .N_LINES(N_LINES)
  ) u_enc (
    .req_i(eff_w),
    .any_o(any_w),
    .id_o (id_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      id_q  <= '0;
    end else begin
      irq_q <= gie_w & any_w;
      id_q  <= id_w;
    end
  end

  assign irq_o    = irq_q;
  assign irq_id_o = id_q;
endmodule

// File: rtl/cpu_irq_unit_chk.sv
module cpu_irq_unit_chk #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned N_SW    = 2,
  localparam int unsigned ID_W   = $clog2(N_LINES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic               addr_i,
  input logic               irq_o,
  input logic [ID_W-1:0]    irq_id_o,
  input logic               gie_i,
  input logic [N_LINES-1:0] mask_i,
  input logic [N_SW-1:0]    sw_i,
  input logic [N_LINES-1:0] lines_i
);
  // R6
  irq_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(gie_i));

  // R6
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_i && (|(lines_i & mask_i))) |=> irq_o);

  // R7
  id_highest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (($past(lines_i & mask_i) >> irq_id_o) == N_LINES'(1)));

  // R3
  sw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i) |=> $stable(sw_i));

  // R2
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && !addr_i) |=> ($stable(mask_i) && $stable(gie_i)));
endmodule

bind cpu_irq_unit cpu_irq_unit_chk #(
  .N_LINES(N_LINES),
  .N_SW   (N_SW)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .irq_o   (irq_o),
  .irq_id_o(irq_id_o),
  .gie_i   (gie_w),
  .mask_i  (mask_w),
  .sw_i    (sw_w),
  .lines_i (lines_w)
);

// File: tb/tb_cpu_irq_unit.sv
`timescale 1ns/1ps
module tb_cpu_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [5:0]  hw = '0;
  logic        tmr = 1'b0;
  logic        irq;
  logic [2:0]  irq_id;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic       irq;
    logic [2:0] id;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  logic [15:0] m_status = '0;
  logic [1:0]  m_sw = '0;

  always #5 clk = ~clk;

  cpu_irq_unit dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .hw_irq_i   (hw),
    .timer_irq_i(tmr),
    .irq_o      (irq),
    .irq_id_o   (irq_id)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_lines(logic [5:0] h, logic t);
    return {t, h[4:0], m_sw};
  endfunction

  // drive one cycle, optionally check read-back, push expected registered outputs
  task automatic step(logic w, logic a, logic [15:0] d, logic [5:0] h, logic t,
                      bit rd, string tag);
    logic [7:0] eff;
    exp_t e;
    @(negedge clk);
    we = w; addr = a; wdata = d; hw = h; tmr = t;
    eff = m_lines(h, t) & m_status[15:8];
    e.irq = m_status[0] && (eff != 8'h00);
    e.id = 3'd0;
    for (int i = 0; i < 8; i++) if (eff[i]) e.id = 3'(i);
    e.tag = tag;
    if (rd) begin
      #1;
      chk({tag, " rdata"}, 32'(rdata),
          a ? 32'({m_lines(h, t), 8'h00}) : 32'(m_status));
    end
    @(posedge clk);
    if (w && !a) m_status = d;
    if (w && a)  m_sw = d[9:8];
    #1;
    exp_q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " irq_o"}, 32'(irq), 32'(e.irq));
        chk({e.tag, " irq_id_o"}, 32'(irq_id), 32'(e.id));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq_o", 32'(irq), 0);
    chk("R1 irq_id_o", 32'(irq_id), 0);
    addr = 1'b0; #1;
    chk("R1 status", 32'(rdata), 0);
    addr = 1'b1; #1;
    chk("R1 cause", 32'(rdata), 0);
    rst_n = 1'b1;

    step(0, 0, 16'h0000, 6'h00, 0, 1, "R1 after release");
    // R2 full status write and read-back
    step(1, 0, 16'hFFFF, 6'h00, 0, 1, "R2 write all");
    step(0, 0, 16'h0000, 6'h00, 0, 1, "R2 readback");
    // R3 cause write only keeps bits 9:8
    step(1, 1, 16'hFFFF, 6'h00, 0, 1, "R3 write all ones");
    step(0, 1, 16'h0000, 6'h00, 0, 1, "R3 only sw bits, R7 id 1");
    step(1, 1, 16'h0100, 6'h00, 0, 0, "R3 clear sw1");
    step(0, 1, 16'h0000, 6'h00, 0, 1, "R3 sw0 left, R7 id 0");
    // R4 hardware line 6 live and not clearable
    step(0, 1, 16'h0000, 6'h10, 0, 1, "R4 line6 level");
    step(1, 1, 16'h0000, 6'h10, 0, 1, "R4 write zero");
    step(0, 1, 16'h0000, 6'h10, 0, 1, "R4 still set");
    // R5 line 7 from timer, hw top pin ignored
    step(0, 1, 16'h0000, 6'h10, 1, 1, "R5 timer line7");
    step(0, 1, 16'h0000, 6'h30, 0, 1, "R5 hw5 ignored");
    step(0, 1, 16'h0000, 6'h20, 0, 1, "R5 hw5 alone");
    // R8 global enable off, id still reported (R7)
    step(1, 0, 16'hFF00, 6'h1F, 1, 0, "R8 gie off");
    step(0, 0, 16'h0000, 6'h1F, 1, 1, "R8 gie off held");
    step(0, 0, 16'h0000, 6'h03, 0, 0, "R8 R7 several lines");
    // R8 per-line mask
    step(1, 0, 16'hBF01, 6'h10, 0, 0, "R8 mask line6 off");
    step(0, 0, 16'h0000, 6'h10, 0, 1, "R8 masked line");
    step(1, 1, 16'h0000, 6'h10, 0, 0, "R8 clear sw");
    step(0, 0, 16'h0000, 6'h10, 0, 0, "R8 masked only");
    // R6 R7 walk each hardware line alone
    for (int n = 2; n < 7; n++) begin
      step(1, 0, 16'((1 << (8 + n)) | 1), 6'(1 << (n - 2)), 0, 0, "R6 walk set");
      step(0, 1, 16'h0000, 6'(1 << (n - 2)), 0, 1, "R6 R7 walk line");
      step(0, 1, 16'h0000, 6'(1 << (n - 2)), 0, 0, "R6 R7 walk hold");
    end
    // R6 request drops with the level
    step(0, 1, 16'h0000, 6'h00, 0, 1, "R6 release");
    step(0, 1, 16'h0000, 6'h00, 0, 0, "R6 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule